// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block is the slave-side front end of a word-organized serial non-volatile memory. A host drives an active-low select, a serial clock and a data line. The block drives a data-out bit together with an output-enable, standing in for a three-state pin. Every serial line is brought into the core clock domain and its edges are found there. The block needs no second clock.

The level of the serial clock at the moment select falls picks one of two modes. With the clock high, the block receives an instruction. Each instruction is one opcode byte and one address byte, and read and write add a 16-bit word. All fields arrive most significant bit first. With the clock low, the block reports ready or busy on data-out.

The block does three things with a decoded instruction:
- A read streams words from a behavioural word array. The address advances after each word and wraps at the top.
- A completed write becomes a one-cycle request that carries the address and the data.
- Write-enable and write-disable become one-cycle pulses.

A separate write controller owns write protection and programming time. That controller updates the array through a commit port.

The depth parameter chooses 128, 256 or 512 words:
- At 256 words the address byte is the word address.
- At 512 words the extra top address bit takes the last position of the read and write opcodes.
- At 128 words the address sits in byte bits 7:1 and bit 0 is ignored.

Top module: `smem_slave`

## Requirements
- R1: A falling `sel_n` while `sck` is high starts instruction reception with `sdo_oe` low. A falling `sel_n` while `sck` is low starts status mode with `sdo_oe` high.
- R2: In instruction reception, `sdi` is sampled only on rising `sck` edges, most significant bit first: 8 opcode bits, 8 address bits, then 16 data bits for read and write.
- R3: Opcode values are 8'hA8 read, 8'hA4 write, 8'hA3 write-enable and 8'hA0 write-disable. With 128 words the word address is address-byte bits 7:1 and bit 0 has no effect.
- R4: For a read, `sdo_oe` stays low through the 16th rising edge. On the 17th falling edge `sdo_oe` goes high and `sdo` shows bit 15 of the addressed word. Each later falling edge presents the next lower bit, and `sdo` changes at no other time.
- R5: While the clock keeps running in a read, the address advances by one after every 16 bits and wraps from DEPTH-1 to 0.
- R6: A write raises `wr_req` for exactly one cycle after the 32nd rising edge. `wr_addr` and `wr_data` carry the framed address and word.
- R7: Write-enable raises `wen_set` for one cycle after the 16th rising edge, and write-disable raises `wen_clr` the same way. The address byte is don't-care for both.
- R8: A rise of `sel_n` before an instruction completes abandons it. No request or pulse is issued, and `sdo_oe` drops.
- R9: In status mode `sdo` is 1 when `busy_in` is low and 0 when it is high. Status output ends when `sel_n` rises or when a rising edge samples `sdi`=1. That 1 is the first opcode bit of an instruction that is then received normally.
- R10: An opcode outside the four valid codes, including the write-all code 8'hAF, is ignored until `sel_n` rises: no request, no pulse, `sdo_oe` low.
- R11: After reset and whenever the block is neither in read output nor in status mode, `sdo_oe` is low.
- R12: The array changes only through the commit port. A commit of `cmt_data` at `cmt_addr` is visible to later reads, and a write request that is not committed leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| busy_in | input | 1 | Busy flag from the write controller |
| cmt_en | input | 1 | Commit strobe from the write controller |
| cmt_addr | input | AW | Commit word address |
| cmt_data | input | 16 | Commit word value |
| sdo | output | 1 | Serial data-out bit |
| sdo_oe | output | 1 | Output enable for the data-out pin |
| wr_req | output | 1 | One-cycle write request |
| wr_addr | output | AW | Write request address |
| wr_data | output | 16 | Write request word |
| wen_set | output | 1 | Write-enable instruction pulse |
| wen_clr | output | 1 | Write-disable instruction pulse |

## Verification
A write sweep over all 128 addresses, each with a distinct arithmetic word, shows whether framing is MSB-first and whether an address bit is dropped. A read stream that runs through the whole array and past the top separates a correct wrap from a stuck or skipped increment. Headers that stop at every phase, invalid opcodes, and address bytes with a set trailing bit show that only complete, valid frames act. Status sessions with each busy level, followed by leading zeros and then a 1, tell the status-exit rule apart from a select-rise-only exit.

// File: rtl/smem_pkg.sv
package smem_pkg;

  localparam int WORD_W = 16;

  localparam logic [7:0] OP_READ  = 8'hA8;
  localparam logic [7:0] OP_WRITE = 8'hA4;
  localparam logic [7:0] OP_WREN  = 8'hA3;
  localparam logic [7:0] OP_WRDS  = 8'hA0;

  typedef enum logic [2:0] {K_READ, K_WRITE, K_WREN, K_WRDS, K_BAD} cmd_e;
  typedef enum logic [2:0] {S_IDLE, S_RX, S_RD, S_STAT, S_IGN} st_e;

  // The 512-word layout drops opcode bit 0 when matching read and write.
  function automatic cmd_e classify(input int unsigned depth, input logic [7:0] op);
    logic [7:0] m;
    m = (depth > 256) ? {op[7:1], 1'b0} : op;
    if (op == OP_WREN) return K_WREN;
    if (op == OP_WRDS) return K_WRDS;
    if (m == OP_READ)  return K_READ;
    if (m == OP_WRITE) return K_WRITE;
    return K_BAD;
  endfunction

  // Word address from the opcode byte and the address byte.
  function automatic int unsigned frame_addr(input int unsigned depth,
                                             input logic [7:0] op,
                                             input logic [7:0] ab);
    if (depth > 256) return int'({op[0], ab});
    if (depth > 128) return int'(ab);
    return int'(ab[7:1]);
  endfunction

  // Next read address, wrapping at the top.
  function automatic int unsigned wrap_inc(input int unsigned depth, input int unsigned a);
    return (a + 1 >= depth) ? 0 : a + 1;
  endfunction

endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST[i];
        s2 <= RST[i];
      end else begin
        s1 <= raw[i];
        s2 <= s1;
      end
    end
    assign lvl[i] = s2;
  end
endmodule

// File: rtl/smem_words.sv
module smem_words #(
  parameter int DEPTH = 128,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmt_en,
  input  logic [AW-1:0] cmt_addr,
  input  logic [W-1:0]  cmt_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_word
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cmt_en) mem[cmt_addr] <= cmt_data;
  end

  assign rd_word = mem[rd_addr];

  // R12: a commit lands in the addressed word
  assert_commit_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_en |=> mem[$past(cmt_addr)] == $past(cmt_data));
endmodule

// File: rtl/smem_frame.sv
module smem_frame
  import smem_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lvl,
  input  logic              sck_lvl,
  input  logic              sdi_lvl,
  input  logic              busy_in,
  input  logic [WORD_W-1:0] rd_word,
  output logic [AW-1:0]     rd_addr,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              wen_set,
  output logic              wen_clr
);
  st_e         st;
  cmd_e        kind_q;
  logic        sel_d, sck_d;
  logic [30:0] shreg;
  logic [4:0]  cnt;
  logic [3:0]  bit_ix;

  // Named events for the logic and the assertions.
  logic        sel_rise, sel_fall, sck_rise, sck_fall;
  logic [31:0] nxt;

  assign sel_rise = sel_lvl & ~sel_d;
  assign sel_fall = ~sel_lvl & sel_d;
  assign sck_rise = sck_lvl & ~sck_d;
  assign sck_fall = ~sck_lvl & sck_d;
  assign nxt      = {shreg, sdi_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      sel_d <= sel_lvl;
      sck_d <= sck_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind_q  <= K_BAD;
      shreg   <= '0;
      cnt     <= '0;
      bit_ix  <= 4'd15;
      rd_addr <= '0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wen_set <= 1'b0;
      wen_clr <= 1'b0;
    end else begin
      wr_req  <= 1'b0;
      wen_set <= 1'b0;
      wen_clr <= 1'b0;
      if (sel_rise) begin
        st     <= S_IDLE;
        sdo    <= 1'b0;
        sdo_oe <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            if (sel_fall) begin
              shreg <= '0;
              cnt   <= '0;
              st    <= sck_lvl ? S_RX : S_STAT;
            end
          end
          S_STAT: begin
            sdo_oe <= 1'b1;
            sdo    <= ~busy_in;
            if (sck_rise && sdi_lvl) begin
              sdo_oe <= 1'b0;
              sdo    <= 1'b0;
              shreg  <= 31'd1;
              cnt    <= 5'd1;
              st     <= S_RX;
            end
          end
          S_RX: begin
            if (sck_rise) begin
              shreg <= nxt[30:0];
              cnt   <= cnt + 5'd1;
              if (cnt == 5'd7) begin
                kind_q <= classify(DEPTH, nxt[7:0]);
                if (classify(DEPTH, nxt[7:0]) == K_BAD) st <= S_IGN;
              end else if (cnt == 5'd15) begin
                case (kind_q)
                  K_READ: begin
                    rd_addr <= AW'(frame_addr(DEPTH, nxt[15:8], nxt[7:0]));
                    bit_ix  <= 4'd15;
                    st      <= S_RD;
                  end
                  K_WREN: begin
                    wen_set <= 1'b1;
                    st      <= S_IGN;
                  end
                  K_WRDS: begin
                    wen_clr <= 1'b1;
                    st      <= S_IGN;
                  end
                  default: ;
                endcase
              end else if (cnt == 5'd31) begin
                wr_req  <= 1'b1;
                wr_addr <= AW'(frame_addr(DEPTH, nxt[31:24], nxt[23:16]));
                wr_data <= nxt[15:0];
                st      <= S_IGN;
              end
            end
          end
          S_RD: begin
            if (sck_fall) begin
              sdo    <= rd_word[bit_ix];
              sdo_oe <= 1'b1;
              if (bit_ix == 4'd0) begin
                bit_ix  <= 4'd15;
                rd_addr <= AW'(wrap_inc(DEPTH, 32'(rd_addr)));
              end else begin
                bit_ix <= bit_ix - 4'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: a select rise silences data-out on the next cycle
  assert_oe_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> !sdo_oe);

  // R11: a settled idle state drives nothing
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st == S_IDLE)) |-> (!sdo_oe && !wr_req));

  // R4: read data moves only after a falling serial clock
  assert_rd_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && $past(st == S_RD) && !$past(sck_fall)) |-> $stable(sdo));

  // R2: the input shifter moves only after a rising serial clock
  assert_sample_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && $past(st == S_RX) && !$past(sck_rise)) |-> $stable(shreg));

  // R6: the write request is a single-cycle pulse
  assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  // R9: status output follows the inverted busy flag
  assert_status_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STAT && $past(st == S_STAT)) |-> (sdo_oe && sdo == !$past(busy_in)));
endmodule

// File: rtl/smem_slave.sv
module smem_slave
  import smem_pkg::*;
#(
  parameter int  DEPTH = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              busy_in,
  input  logic              cmt_en,
  input  logic [AW-1:0]     cmt_addr,
  input  logic [WORD_W-1:0] cmt_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              wen_set,
  output logic              wen_clr
);
  logic [2:0]        lvl;
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] rd_word;

  smem_sync #(.N(3), .RST(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({sel_n, sck, sdi}),
    .lvl   (lvl)
  );

  smem_words #(.DEPTH(DEPTH), .W(WORD_W)) u_words (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmt_en   (cmt_en),
    .cmt_addr (cmt_addr),
    .cmt_data (cmt_data),
    .rd_addr  (rd_addr),
    .rd_word  (rd_word)
  );

  smem_frame #(.DEPTH(DEPTH)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_lvl (lvl[2]),
    .sck_lvl (lvl[1]),
    .sdi_lvl (lvl[0]),
    .busy_in (busy_in),
    .rd_word (rd_word),
    .rd_addr (rd_addr),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wen_set (wen_set),
    .wen_clr (wen_clr)
  );
endmodule

// File: tb/smem_slave_bench.sv
`timescale 1ns/1ps
module smem_slave_bench;
  localparam int DEPTH = 128;
  localparam int AW    = $clog2(DEPTH);
  localparam int HP    = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic sel_n = 1, sck = 0, sdi = 0, busy_in = 0, allow = 1;
  logic cmt_en;
  logic [AW-1:0] cmt_addr;
  logic [15:0] cmt_data;
  logic sdo, sdo_oe, wr_req, wen_set, wen_clr;
  logic [AW-1:0] wr_addr;
  logic [15:0] wr_data;

  int total = 0, bad = 0;
  int wr_cnt = 0, set_cnt = 0, clr_cnt = 0;
  logic [AW-1:0] last_a = '0;
  logic [15:0] last_d = '0;
  logic [15:0] model [DEPTH];
  bit done = 0;

  always #2 clk = ~clk;

  assign cmt_en   = wr_req & allow;
  assign cmt_addr = wr_addr;
  assign cmt_data = wr_data;

  smem_slave #(.DEPTH(DEPTH)) u_smem_slave (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .busy_in(busy_in), .cmt_en(cmt_en), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
    .sdo(sdo), .sdo_oe(sdo_oe), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wen_set(wen_set), .wen_clr(wen_clr)
  );

  always @(posedge clk) begin
    if (rst_n && wr_req) begin
      wr_cnt <= wr_cnt + 1;
      last_a <= wr_addr;
      last_d <= wr_data;
    end
    if (rst_n && wen_set) set_cnt <= set_cnt + 1;
    if (rst_n && wen_clr) clr_cnt <= clr_cnt + 1;
  end

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 40503) ^ 23130);
  endfunction

  task automatic tk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic go_cmd();   sck = 1; tk(HP); sel_n = 0; tk(HP); endtask
  task automatic go_stat();  sck = 0; tk(HP); sel_n = 0; tk(HP); endtask
  task automatic stop();     sel_n = 1; tk(HP); endtask
  task automatic bit_out(input bit b); sck = 0; sdi = b; tk(HP); sck = 1; tk(HP); endtask
  task automatic byte_out(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
  endtask
  task automatic bit_in(output bit b, output bit oe);
    sck = 0; tk(HP); b = sdo; oe = sdo_oe; sck = 1; tk(HP);
  endtask
  task automatic word_in(output logic [15:0] w, output bit oe_all);
    bit b, oe;
    oe_all = 1;
    for (int i = 15; i >= 0; i--) begin
      bit_in(b, oe);
      w[i] = b;
      oe_all &= oe;
    end
  endtask
  task automatic write_frame(input logic [7:0] ab, input logic [15:0] d);
    go_cmd(); byte_out(8'hA4); byte_out(ab); byte_out(d[15:8]); byte_out(d[7:0]);
    tk(2); stop();
  endtask

  initial begin
    logic [15:0] w;
    bit oe, b;
    int n0;
    tk(3);
    rst_n = 1;
    tk(4);
    // R11: reset state
    chk(sdo_oe == 0 && wr_cnt == 0, "R11", "reset oe/requests", int'(sdo_oe), 0);

    // R6 R2: write sweep over every address
    for (int a = 0; a < DEPTH; a++) begin
      n0 = wr_cnt;
      go_cmd(); byte_out(8'hA4); byte_out({7'(a), 1'b0});
      byte_out(pat(a) >> 8); byte_out(pat(a) & 16'hFF);
      tk(2);
      chk(wr_cnt == n0 + 1 && int'(last_a) == a, "R6", "write pulse/addr", int'(last_a), a);
      chk(last_d == pat(a), "R2", "write data msb-first", int'(last_d), int'(pat(a)));
      stop();
      model[a] = pat(a);
    end

    // R4: single read, output timing
    go_cmd(); byte_out(8'hA8); byte_out({7'd5, 1'b0});
    chk(sdo_oe == 0, "R4", "oe before 17th fall", int'(sdo_oe), 0);
    bit_in(b, oe);
    chk(oe == 1 && b == model[5][15], "R4", "first bit at 17th fall", int'(b), int'(model[5][15]));
    stop();

    // R5: stream through whole array and past the top
    go_cmd(); byte_out(8'hA8); byte_out(8'h00);
    for (int k = 0; k <= DEPTH; k++) begin
      word_in(w, oe);
      chk(oe && w == model[k % DEPTH], "R5", "streamed word", int'(w), int'(model[k % DEPTH]));
    end
    stop();
    // R11: quiet after select rise
    chk(sdo_oe == 0, "R11", "oe after read end", int'(sdo_oe), 0);

    // R3: trailing address bit has no effect
    go_cmd(); byte_out(8'hA8); byte_out({7'd9, 1'b1});
    word_in(w, oe);
    chk(w == model[9], "R3", "read with trailing 1", int'(w), int'(model[9]));
    stop();
    write_frame({7'd20, 1'b1}, 16'hC3C3);
    model[20] = 16'hC3C3;
    chk(int'(last_a) == 20, "R3", "write addr trailing 1", int'(last_a), 20);
    go_cmd(); byte_out(8'hA8); byte_out({7'd20, 1'b0});
    word_in(w, oe);
    chk(w == 16'hC3C3, "R3", "readback of trailing-1 write", int'(w), 16'hC3C3);
    stop();

    // R12: uncommitted write leaves the word alone
    allow = 0;
    n0 = wr_cnt;
    write_frame({7'd30, 1'b0}, 16'h1234);
    allow = 1;
    chk(wr_cnt == n0 + 1, "R12", "request still issued", wr_cnt, n0 + 1);
    go_cmd(); byte_out(8'hA8); byte_out({7'd30, 1'b0});
    word_in(w, oe);
    chk(w == model[30], "R12", "word unchanged", int'(w), int'(model[30]));
    stop();

    // R8: abandoned write, enable and read
    n0 = wr_cnt;
    go_cmd(); byte_out(8'hA4); byte_out(8'h10); byte_out(8'hFF); bit_out(1); stop();
    tk(4);
    chk(wr_cnt == n0, "R8", "abandoned write", wr_cnt, n0);
    n0 = set_cnt;
    go_cmd(); byte_out(8'hA3); for (int i = 0; i < 4; i++) bit_out(0); stop();
    chk(set_cnt == n0, "R8", "abandoned enable", set_cnt, n0);
    go_cmd(); byte_out(8'hA8); byte_out(8'h00);
    for (int i = 0; i < 5; i++) bit_in(b, oe);
    stop();
    chk(sdo_oe == 0, "R8", "oe after abandoned read", int'(sdo_oe), 0);

    // R7: enable and disable pulses
    n0 = set_cnt;
    go_cmd(); byte_out(8'hA3); byte_out(8'h5A); tk(2);
    chk(set_cnt == n0 + 1, "R7", "enable pulse", set_cnt, n0 + 1);
    stop();
    n0 = clr_cnt;
    go_cmd(); byte_out(8'hA0); byte_out(8'hC7); tk(2);
    chk(clr_cnt == n0 + 1, "R7", "disable pulse", clr_cnt, n0 + 1);
    stop();

    // R10: invalid opcodes ignored
    foreach (model[i]) if (i < 5) begin
      logic [7:0] op;
      case (i)
        0: op = 8'hAF;
        1: op = 8'hA1;
        2: op = 8'h28;
        3: op = 8'hA9;
        default: op = 8'hFF;
      endcase
      n0 = wr_cnt + set_cnt + clr_cnt;
      go_cmd(); byte_out(op); byte_out(8'h00); byte_out(8'hFF); byte_out(8'hFF);
      tk(2);
      chk(wr_cnt + set_cnt + clr_cnt == n0 && sdo_oe == 0, "R10", "bad opcode ignored",
          int'(op), 0);
      stop();
    end

    // R1: mode chosen by clock level
    go_cmd();
    chk(sdo_oe == 0, "R1", "clock high -> receive", int'(sdo_oe), 0);
    stop();
    busy_in = 1;
    go_stat();
    chk(sdo_oe == 1, "R1", "clock low -> status", int'(sdo_oe), 1);
    // R9: status levels and exit
    chk(sdo == 0, "R9", "busy shows 0", int'(sdo), 0);
    busy_in = 0; tk(4);
    chk(sdo == 1, "R9", "ready shows 1", int'(sdo), 1);
    bit_out(0); bit_out(0);
    chk(sdo_oe == 1, "R9", "zeros keep status", int'(sdo_oe), 1);
    n0 = set_cnt;
    bit_out(1);
    chk(sdo_oe == 0, "R9", "first 1 ends status", int'(sdo_oe), 0);
    bit_out(0); bit_out(1); bit_out(0); bit_out(0); bit_out(0); bit_out(1); bit_out(1);
    byte_out(8'h00); tk(2);
    chk(set_cnt == n0 + 1, "R9", "instruction after status", set_cnt, n0 + 1);
    stop();
    go_stat();
    stop();
    chk(sdo_oe == 0, "R11", "status ends on select rise", int'(sdo_oe), 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule